// File: doc/BRIEF.md
# Transmit Empty Status Tracker

This block keeps the two transmitter status flags of a serial port: "holding stage empty", which tells software it may write another character, and "transmitter fully empty", which says that neither the holding stage nor the shift register has data left. It also raises an interrupt request while the holding stage is empty and software has enabled that interrupt.

The port can run with a single holding register or with a transmit FIFO. In single-register mode, the events that move the holding flag are CPU writes and the transfer of a character into the shift register. In FIFO mode, the flag follows the FIFO occupancy count, and a write clears it at once. The serializer reports when it loads a character and when it finishes shifting one. From those two events the block tracks whether the shift register is busy. Both flags are registered and have no write path.

Top module: `tx_empty_status`

## Requirements
- R1: After reset, `thre` = 1 and `temt` = 1, and `thre_irq` equals `thre_ie`.
- R2: In single-register mode (`fifo_mode` = 0), a `shift_load` pulse with no `hold_wr` sets `thre` to 1 at the next clock edge.
- R3: In single-register mode, a `hold_wr` pulse clears `thre` to 0 at the next clock edge.
- R4: When `hold_wr` and `shift_load` are both high in the same cycle, the write takes priority and `thre` is 0 after the edge.
- R5: In FIFO mode (`fifo_mode` = 1), after each edge `thre` is 1 exactly when `occ` was 0 and `hold_wr` was low in the cycle before that edge. Otherwise `thre` is 0.
- R6: The shift register becomes busy on `shift_load` and becomes idle on `shift_done`. If both arrive together, it stays busy. After each edge, `temt` = `thre` AND (shift register idle), and both are updated on the same edge.
- R7: The status bits have no write path. In single-register mode with no `hold_wr`, `shift_load` or `shift_done`, `thre` and `temt` keep their values on every edge.
- R8: `thre_irq` is high exactly when `thre` and `thre_ie` are both high. It follows a change of `thre_ie` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects single-register mode |
| hold_wr | input | 1 | CPU write strobe to the holding register or FIFO |
| occ | input | OCC_W | Transmit FIFO occupancy count |
| shift_load | input | 1 | A character moves into the shift register |
| shift_done | input | 1 | The shift register has sent its last bit |
| thre_ie | input | 1 | Holding-empty interrupt enable |
| thre | output | 1 | Holding stage empty flag |
| temt | output | 1 | Holding stage and shift register both empty |
| thre_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `OCC_W` = 3. At that width the full occupancy value 7 can be driven, along with 0 and the values in between, so the FIFO-mode rule is checked at both ends of the count. A reference model in the bench predicts both flags and the interrupt for every cycle. The stimulus covers the priority cases directly: a write and a load in the same cycle, a load and a shift completion in the same cycle, and a write while the FIFO reports empty.

// File: rtl/tx_empty_status.sv
module tx_empty_status #(
  parameter int OCC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             hold_wr,
  input  logic [OCC_W-1:0] occ,
  input  logic             shift_load,
  input  logic             shift_done,
  input  logic             thre_ie,
  output logic             thre,
  output logic             temt,
  output logic             thre_irq
);

  logic busy_q;
  logic thre_d, busy_d;
  logic occ_zero;

  assign occ_zero = (occ == '0);

  always_comb begin
    if (hold_wr)        thre_d = 1'b0;
    else if (fifo_mode) thre_d = occ_zero;
    else if (shift_load) thre_d = 1'b1;
    else                thre_d = thre;
  end

  always_comb begin
    if (shift_load)      busy_d = 1'b1;
    else if (shift_done) busy_d = 1'b0;
    else                 busy_d = busy_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thre   <= 1'b1;
      busy_q <= 1'b0;
      temt   <= 1'b1;
    end else begin
      thre   <= thre_d;
      busy_q <= busy_d;
      temt   <= thre_d & ~busy_d;
    end
  end

  assign thre_irq = thre & thre_ie;

  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> !thre); // R3
  AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && shift_load && !hold_wr) |=> thre); // R2
  AST_FIFO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && occ_zero && !hold_wr) |=> thre); // R5
  AST_FIFO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && !occ_zero) |=> !thre); // R5
  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    temt |-> thre); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !hold_wr && !shift_load && !shift_done) |=> ($stable(thre) && $stable(temt))); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq |-> (thre_ie && thre)); // R8

endmodule

// File: tb/sim_tx_empty_status.sv
module sim_tx_empty_status;
  localparam int PER   = 10;
  localparam int OCC_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b0, hold_wr = 1'b0, shift_load = 1'b0, shift_done = 1'b0, thre_ie = 1'b0;
  logic [OCC_W-1:0] occ = '0;
  logic thre, temt, thre_irq;

  typedef struct {
    logic  thre;
    logic  temt;
    logic  irq;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic m_thre, m_busy;

  always #(PER/2) clk = ~clk;

  tx_empty_status #(.OCC_W(OCC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .hold_wr(hold_wr), .occ(occ),
    .shift_load(shift_load), .shift_done(shift_done), .thre_ie(thre_ie),
    .thre(thre), .temt(temt), .thre_irq(thre_irq)
  );

  task automatic chk(input logic act, input logic exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic fm, input logic wr, input logic [OCC_W-1:0] o,
                      input logic ld, input logic dn, input logic ie, input string tag);
    exp_t e;
    @(negedge clk);
    fifo_mode = fm; hold_wr = wr; occ = o; shift_load = ld; shift_done = dn; thre_ie = ie;
    if (wr) m_thre = 1'b0;
    else if (fm) m_thre = (o == 0);
    else if (ld) m_thre = 1'b1;
    if (ld) m_busy = 1'b1;
    else if (dn) m_busy = 1'b0;
    e.thre = m_thre; e.temt = m_thre & ~m_busy; e.irq = m_thre & ie; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #(PER/4);
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk(thre, e.thre, "thre", e.tag);
      chk(temt, e.temt, "temt", e.tag);
      chk(thre_irq, e.irq, "thre_irq", e.tag);
    end
  end

  initial begin
    #(PER*200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_thre = 1'b1; m_busy = 1'b0;
    thre_ie = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(thre, 1'b1, "thre", "R1");
    chk(temt, 1'b1, "temt", "R1");
    chk(thre_irq, 1'b1, "thre_irq", "R1");
    thre_ie = 1'b0;
    #1 chk(thre_irq, 1'b0, "thre_irq", "R1");
    rst_n = 1'b1;

    step(0, 1, 0, 0, 0, 1, "R3");
    step(0, 0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, 0, 1, "R2");
    step(0, 0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 1, 1, "R6");
    step(0, 1, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 1, 0, 1, "R4");
    step(0, 0, 0, 1, 0, 1, "R2");
    step(0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 1, 1, "R6");
    step(0, 0, 0, 0, 1, 1, "R6");
    repeat (4) step(0, 0, 0, 0, 0, 1, "R7");
    step(1, 0, 3, 0, 0, 1, "R5");
    step(1, 0, 7, 0, 0, 1, "R5");
    step(1, 0, 0, 0, 0, 1, "R5");
    step(1, 1, 0, 0, 0, 1, "R5");
    step(1, 0, 1, 1, 0, 1, "R5");
    step(1, 0, 0, 0, 0, 1, "R6");
    step(1, 0, 0, 0, 1, 1, "R6");
    step(1, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, "R7");
    repeat (3) @(posedge clk);
    #(PER/2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule